// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Bank

This block is the register file that software uses to program a small multi-channel DMA controller. It answers a zero-wait 32-bit APB-style slave port. It keeps one shared status word and one shared write-one-to-clear word. Each channel has a group of four registers: control, item count, peripheral-side address and memory-side address. The groups repeat at a stride of 20 bytes, and up to eight channels are supported.

The transfer engines report three kinds of event with single-cycle pulses: done, half-way and fault. The bank latches each pulse as a sticky flag in that channel's 4-bit field of the status word. It drives one interrupt line per channel, qualified by that channel's interrupt-enable bits. The engines read their channel's control fields, count and addresses from flat output buses. A fault pulse also drops the channel's run bit, so software reads back the stopped state.

Top module: `dma_regbank`

## Requirements
- R1: After a synchronous reset, every register reads as zero, every interrupt line is low, and every engine-facing output is zero.
- R2: Channel i owns status bits 4i+3..4i at offset 0x0: bit 4i+1 = done, bit 4i+2 = half-way, bit 4i+3 = fault. A one-cycle event pulse sets its flag at the next clock edge. The flag then stays set until software clears it.
- R3: Bit 4i of the status word is read-only and always reads as the OR of channel i's three flags. Writing a 1 to that position in the clear word changes nothing.
- R4: A write to offset 0x4 clears every status flag whose bit position holds a 1 and leaves the other flags alone. Offset 0x4 reads as zero. Writes to the status word at 0x0 have no effect.
- R5: If an event pulse and a clear of the same flag land on the same clock edge, the flag is set after that edge.
- R6: irq[i] is high exactly when (done AND bit 1) OR (half-way AND bit 2) OR (fault AND bit 3) holds, where the bits are channel i's control register bits.
- R7: Channel i's registers sit at 0x08+0x14*i (control), 0x0C+0x14*i (count), 0x10+0x14*i (peripheral address) and 0x14+0x14*i (memory address). Each reads back what was last written to it.
- R8: The control register keeps bits 14:0 (0 run, 1 done-irq enable, 2 half-irq enable, 3 fault-irq enable, 4 direction, 5 wrap, 6 peripheral step, 7 memory step, 9:8 peripheral item size, 11:10 memory item size, 13:12 priority, 14 memory-to-memory). Control bits 31:15 and count bits 31:16 read as zero, and writes to them are ignored.
- R9: A fault pulse clears the channel's run bit (control bit 0) at the same edge that sets the fault flag. This also applies when a software write that sets the run bit lands on that edge, and a read then shows the run bit as zero.
- R10: A read of any offset not listed in R4 or R7 (beyond the last channel, or not word-aligned) returns zero, and a write to such an offset changes no register.
- R11: cfg_o[15i+14:15i], cnt_o[16i+15:16i], per_addr_o[32i+31:32i] and mem_addr_o[32i+31:32i] always carry channel i's current control, count and address register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected for a read |
| ev_done | input | NUM_CH (8) | Per-channel done pulse |
| ev_half | input | NUM_CH (8) | Per-channel half-way pulse |
| ev_fault | input | NUM_CH (8) | Per-channel fault pulse |
| irq | output | NUM_CH (8) | Per-channel interrupt line |
| cfg_o | output | 15*NUM_CH | Control register of every channel |
| cnt_o | output | 16*NUM_CH | Item count of every channel |
| per_addr_o | output | 32*NUM_CH | Peripheral address of every channel |
| mem_addr_o | output | 32*NUM_CH | Memory address of every channel |

## Verification
A wrong flag bit shows up one edge after the event or clear that caused it, in two places: the status readback and the matching irq line. A fault that fails to stop the channel shows up at once as a set run bit, both in the control readback and on cfg_o. A stride or decode mistake sends a write into a neighbour's register, so the bench reads back the last channel and an offset just past it, and also re-reads registers after misaligned writes. The same-edge races are driven by aligning the event pulse with the access phase. This covers fault against a write that sets the run bit, and event against a clear.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;

    localparam int DATA_W   = 32;
    localparam int CFG_W    = 15;
    localparam int CNT_W    = 16;
    localparam int NIB_W    = 4;
    localparam int OFF_STAT = 'h00;
    localparam int OFF_CLR  = 'h04;
    localparam int GRP_BASE = 'h08;
    localparam int GRP_STEP = 'h14;

    typedef struct packed {
        logic       m2m;
        logic [1:0] prio;
        logic [1:0] msize;
        logic [1:0] psize;
        logic       mstep;
        logic       pstep;
        logic       wrap;
        logic       dir;
        logic       fault_ie;
        logic       half_ie;
        logic       done_ie;
        logic       run;
    } ctrl_t;

    typedef struct packed {
        logic fault;
        logic half;
        logic done;
    } flags_t;

    function automatic logic [NIB_W-1:0] pack_nibble(flags_t f);
        return {f.fault, f.half, f.done, (f.fault | f.half | f.done)};
    endfunction

    function automatic logic want_irq(flags_t f, ctrl_t c);
        return (f.done & c.done_ie) | (f.half & c.half_ie) | (f.fault & c.fault_ie);
    endfunction

endpackage

// File: rtl/dmarb_apb_decode.sv
module dmarb_apb_decode
    import dmarb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic              wr_go,
    output logic              rd_sel,
    output logic              stat_hit,
    output logic              clr_hit
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(OFF_CLR);

    always_comb begin
        wr_go    = psel & penable & pwrite;
        rd_sel   = psel & ~pwrite;
        stat_hit = (paddr == STAT_A);
        clr_hit  = (paddr == CLR_A);
    end
endmodule

// File: rtl/dmarb_chan_regs.sv
module dmarb_chan_regs
    import dmarb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic              fault_ev,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [DATA_W-1:0] pa_q,
    output logic [DATA_W-1:0] ma_q,
    output logic              hit,
    output logic [DATA_W-1:0] rd_data
);
    localparam int BASE = GRP_BASE + GRP_STEP * CH_IDX;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(BASE + 4);
    localparam logic [ADDR_W-1:0] A_PA   = ADDR_W'(BASE + 8);
    localparam logic [ADDR_W-1:0] A_MA   = ADDR_W'(BASE + 12);

    logic  h_ctrl, h_cnt, h_pa, h_ma;
    ctrl_t ctrl_nx;

    always_comb begin
        h_ctrl = (paddr == A_CTRL);
        h_cnt  = (paddr == A_CNT);
        h_pa   = (paddr == A_PA);
        h_ma   = (paddr == A_MA);
        hit    = h_ctrl | h_cnt | h_pa | h_ma;
    end

    // Fault from the engine overrides any software write of the run bit.
    always_comb begin
        ctrl_nx = ctrl_q;
        if (wr_go && h_ctrl) ctrl_nx = ctrl_t'(pwdata[CFG_W-1:0]);
        if (fault_ev)        ctrl_nx.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
            pa_q   <= '0;
            ma_q   <= '0;
        end else begin
            ctrl_q <= ctrl_nx;
            if (wr_go && h_cnt) cnt_q <= pwdata[CNT_W-1:0];
            if (wr_go && h_pa)  pa_q  <= pwdata;
            if (wr_go && h_ma)  ma_q  <= pwdata;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            if (h_ctrl) rd_data = {{(DATA_W-CFG_W){1'b0}}, ctrl_q};
            if (h_cnt)  rd_data = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
            if (h_pa)   rd_data = pa_q;
            if (h_ma)   rd_data = ma_q;
        end
    end

    a_r9_fault_stops_run: assert property (@(posedge clk) disable iff (rst)
        fault_ev |=> !ctrl_q.run);

    a_r8_ctrl_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_sel && h_ctrl) |-> (rd_data[DATA_W-1:CFG_W] == '0));

endmodule

// File: rtl/dmarb_flag_bank.sv
module dmarb_flag_bank
    import dmarb_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ev_done,
    input  logic [NUM_CH-1:0] ev_half,
    input  logic [NUM_CH-1:0] ev_fault,
    input  logic              clr_go,
    input  logic [NUM_CH-1:0] clr_done,
    input  logic [NUM_CH-1:0] clr_half,
    input  logic [NUM_CH-1:0] clr_fault,
    input  ctrl_t             ctrl [NUM_CH],
    output logic [DATA_W-1:0] stat,
    output logic [NUM_CH-1:0] irq
);
    flags_t fl [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic wipe_d, wipe_h, wipe_f;
        assign wipe_d = clr_go & clr_done[i];
        assign wipe_h = clr_go & clr_half[i];
        assign wipe_f = clr_go & clr_fault[i];

        // A new event takes priority over a clear on the same edge.
        always_ff @(posedge clk) begin
            if (rst) begin
                fl[i] <= '0;
            end else begin
                fl[i].done  <= ev_done[i]  | (fl[i].done  & ~wipe_d);
                fl[i].half  <= ev_half[i]  | (fl[i].half  & ~wipe_h);
                fl[i].fault <= ev_fault[i] | (fl[i].fault & ~wipe_f);
            end
        end

        assign irq[i] = want_irq(fl[i], ctrl[i]);

        a_r2_done_sticks: assert property (@(posedge clk) disable iff (rst)
            ev_done[i] |=> fl[i].done);
        a_r5_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
            (ev_fault[i] && wipe_f) |=> fl[i].fault);
        a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
            (wipe_h && !ev_half[i]) |=> !fl[i].half);
        a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
            irq[i] |-> (fl[i] != '0));
    end

    always_comb begin
        stat = '0;
        for (int i = 0; i < NUM_CH; i++) stat[NIB_W*i +: NIB_W] = pack_nibble(fl[i]);
    end

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dmarb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     psel,
    input  logic                     penable,
    input  logic                     pwrite,
    input  logic [ADDR_W-1:0]        paddr,
    input  logic [31:0]              pwdata,
    output logic [31:0]              prdata,
    input  logic [NUM_CH-1:0]        ev_done,
    input  logic [NUM_CH-1:0]        ev_half,
    input  logic [NUM_CH-1:0]        ev_fault,
    output logic [NUM_CH-1:0]        irq,
    output logic [NUM_CH*15-1:0]     cfg_o,
    output logic [NUM_CH*16-1:0]     cnt_o,
    output logic [NUM_CH*32-1:0]     per_addr_o,
    output logic [NUM_CH*32-1:0]     mem_addr_o
);
    logic wr_go, rd_sel, stat_hit, clr_hit;
    logic [NUM_CH-1:0] ch_hit;
    logic [NUM_CH-1:0] clr_d, clr_h, clr_f;
    logic [DATA_W-1:0] ch_rd [NUM_CH];
    logic [DATA_W-1:0] stat;
    ctrl_t             ctrl [NUM_CH];

    dmarb_apb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .wr_go(wr_go), .rd_sel(rd_sel), .stat_hit(stat_hit), .clr_hit(clr_hit)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_grp
        logic [CNT_W-1:0]  cnt_w;
        logic [DATA_W-1:0] pa_w, ma_w;

        dmarb_chan_regs #(.ADDR_W(ADDR_W), .CH_IDX(i)) u_regs (
            .clk(clk), .rst(rst), .wr_go(wr_go), .rd_sel(rd_sel),
            .paddr(paddr), .pwdata(pwdata), .fault_ev(ev_fault[i]),
            .ctrl_q(ctrl[i]), .cnt_q(cnt_w), .pa_q(pa_w), .ma_q(ma_w),
            .hit(ch_hit[i]), .rd_data(ch_rd[i])
        );

        assign cfg_o[CFG_W*i +: CFG_W]       = ctrl[i];
        assign cnt_o[CNT_W*i +: CNT_W]       = cnt_w;
        assign per_addr_o[DATA_W*i +: DATA_W] = pa_w;
        assign mem_addr_o[DATA_W*i +: DATA_W] = ma_w;

        assign clr_d[i] = pwdata[NIB_W*i + 1];
        assign clr_h[i] = pwdata[NIB_W*i + 2];
        assign clr_f[i] = pwdata[NIB_W*i + 3];
    end

    dmarb_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
        .clk(clk), .rst(rst),
        .ev_done(ev_done), .ev_half(ev_half), .ev_fault(ev_fault),
        .clr_go(wr_go & clr_hit),
        .clr_done(clr_d), .clr_half(clr_h), .clr_fault(clr_f),
        .ctrl(ctrl), .stat(stat), .irq(irq)
    );

    always_comb begin
        prdata = '0;
        if (rd_sel && stat_hit) prdata = stat;
        for (int i = 0; i < NUM_CH; i++) prdata = prdata | ch_rd[i];
    end

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_sel && !stat_hit && (ch_hit == '0)) |-> (prdata == '0));

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (irq == '0));

endmodule

// File: tb/dma_regbank_test.sv
module dma_regbank_test;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [NCH-1:0] ev_done = '0, ev_half = '0, ev_fault = '0;
    logic [NCH-1:0] irq;
    logic [NCH*15-1:0] cfg_o;
    logic [NCH*16-1:0] cnt_o;
    logic [NCH*32-1:0] per_addr_o, mem_addr_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    dma_regbank uut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .ev_done(ev_done), .ev_half(ev_half), .ev_fault(ev_fault), .irq(irq),
        .cfg_o(cfg_o), .cnt_o(cnt_o), .per_addr_o(per_addr_o), .mem_addr_o(mem_addr_o)
    );

    // Monitor: pops one expected word per read access phase.
    always @(negedge clk) begin
        #2;
        if (psel && penable && !pwrite && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (prdata !== e) begin
                n_errors++;
                $display("FAIL %s: prdata=%h expected=%h", t, prdata, e);
            end
        end
    end

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] e);
        n_checks++;
        if (act !== e) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", t, act, e);
        end
    endtask

    task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [31:0] e, input string t,
                        input logic [NCH-1:0] vd = '0, input logic [NCH-1:0] vh = '0,
                        input logic [NCH-1:0] vf = '0);
        @(negedge clk);
        psel = 1; pwrite = wr; paddr = a; pwdata = d; penable = 0;
        @(negedge clk);
        if (!wr) begin exp_q.push_back(e); tag_q.push_back(t); end
        penable = 1; ev_done = vd; ev_half = vh; ev_fault = vf;
        @(negedge clk);
        psel = 0; penable = 0; ev_done = '0; ev_half = '0; ev_fault = '0;
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d);
        xfer(1, a, d, '0, "");
    endtask

    task automatic rd32(input logic [7:0] a, input logic [31:0] e, input string t);
        xfer(0, a, '0, e, t);
    endtask

    task automatic pulse(input logic [NCH-1:0] vd, input logic [NCH-1:0] vh,
                         input logic [NCH-1:0] vf);
        @(negedge clk);
        ev_done = vd; ev_half = vh; ev_fault = vf;
        @(negedge clk);
        ev_done = '0; ev_half = '0; ev_fault = '0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        check("R1 irq", {24'b0, irq}, 32'h0);
        check("R1 cfg_o", cfg_o[31:0], 32'h0);
        rd32(8'h00, 32'h0, "R1 status");
        rd32(8'h08, 32'h0, "R1 ch0 ctrl");
        rd32(8'hA0, 32'h0, "R1 ch7 mem addr");

        // R7 / R8 register map and widths
        wr32(8'h08, 32'h0000_7FFF);
        rd32(8'h08, 32'h0000_7FFF, "R7 ch0 ctrl");
        wr32(8'h1C, 32'hFFFF_FFFF);
        rd32(8'h1C, 32'h0000_7FFF, "R8 ch1 ctrl upper bits");
        wr32(8'h34, 32'hFFFF_FFFF);
        rd32(8'h34, 32'h0000_FFFF, "R8 ch2 count upper bits");
        wr32(8'h4C, 32'h1234_5678);
        rd32(8'h4C, 32'h1234_5678, "R7 ch3 periph addr");
        wr32(8'hA0, 32'hCAFE_F00D);
        rd32(8'hA0, 32'hCAFE_F00D, "R7 ch7 mem addr");
        // R11 engine-facing outputs
        check("R11 cfg_o ch0", {17'b0, cfg_o[14:0]}, 32'h7FFF);
        check("R11 cnt_o ch2", {16'b0, cnt_o[47:32]}, 32'hFFFF);
        check("R11 per_addr_o ch3", per_addr_o[127:96], 32'h1234_5678);
        check("R11 mem_addr_o ch7", mem_addr_o[255:224], 32'hCAFE_F00D);

        // R10 unmapped and misaligned
        wr32(8'hA8, 32'hFFFF_FFFF);
        rd32(8'hA8, 32'h0, "R10 beyond last channel");
        wr32(8'h09, 32'h0);
        rd32(8'h09, 32'h0, "R10 misaligned read");
        rd32(8'h08, 32'h0000_7FFF, "R10 misaligned write left ch0");
        wr32(8'h08, 32'h0);

        // R2 / R3 event latching and summary bit
        pulse(8'h04, 8'h00, 8'h00);
        rd32(8'h00, 32'h0000_0300, "R2 ch2 done");
        pulse(8'h00, 8'h20, 8'h20);
        rd32(8'h00, 32'h00D0_0300, "R3 ch5 half+fault");

        // R4 status is read-only; clear semantics
        wr32(8'h00, 32'hFFFF_FFFF);
        rd32(8'h00, 32'h00D0_0300, "R4 status write ignored");
        wr32(8'h04, 32'h0010_0000);
        rd32(8'h00, 32'h00D0_0300, "R3 clear of summary bit ignored");
        rd32(8'h04, 32'h0, "R4 clear reads zero");
        wr32(8'h04, 32'h0040_0000);
        rd32(8'h00, 32'h0090_0300, "R4 clear ch5 half");

        // R6 interrupt gating
        check("R6 ch2 no enable", {31'b0, irq[2]}, 32'h0);
        wr32(8'h30, 32'h2);
        check("R6 ch2 done enabled", {31'b0, irq[2]}, 32'h1);
        wr32(8'h6C, 32'h4);
        check("R6 ch5 half enable, flag clear", {31'b0, irq[5]}, 32'h0);
        wr32(8'h6C, 32'h8);
        check("R6 ch5 fault enabled", {31'b0, irq[5]}, 32'h1);

        // R9 fault stops the channel
        wr32(8'h58, 32'h1);
        check("R9 ch4 run set", {17'b0, cfg_o[74:60]}, 32'h1);
        pulse(8'h00, 8'h00, 8'h10);
        rd32(8'h58, 32'h0, "R9 ch4 run cleared");
        rd32(8'h00, 32'h0099_0300, "R9 ch4 fault flag");
        xfer(1, 8'h58, 32'h9, '0, "", 8'h00, 8'h00, 8'h10);
        rd32(8'h58, 32'h8, "R9 fault wins over write");
        check("R6 ch4 fault irq", {31'b0, irq[4]}, 32'h1);

        // R5 event against clear on the same edge
        xfer(1, 8'h04, 32'h0000_0200, '0, "", 8'h04, 8'h00, 8'h00);
        rd32(8'h00, 32'h0099_0300, "R5 event beats clear");
        wr32(8'h04, 32'h0000_0200);
        rd32(8'h00, 32'h0099_0000, "R4 ch2 done cleared");
        check("R6 ch2 irq dropped", {31'b0, irq[2]}, 32'h0);
        wr32(8'h04, 32'hFFFF_FFFF);
        rd32(8'h00, 32'h0, "R4 clear all");
        check("R6 all irq low", {24'b0, irq}, 32'h0);

        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule